// File: doc/BRIEF.md
# Address-less PROM burn and read-back sequencer

This block sits on the host side of a byte-wide one-time programmable memory that has no address pins. The device keeps an internal address counter. A mode-select code clears that counter, and bursts of clock pulses advance it. The sequencer produces the four mode-select lines, the address clock and the byte bus (bits 3:0 and 7:4 go to the two nibble ports). It also produces three enables: device supply on, programming-pin supply on, and a boost that raises both supplies to their programming levels. Analog regulation is left to the board.

In burn mode the block takes one byte per address from a valid/ready source. It programs each byte with an adaptive loop. It applies 1 ms write pulses, each followed by a read-back, until the device returns the byte. It then applies a single over-programming pulse whose length is the number of pulses already used times 1 ms. When that pulse ends, it acknowledges the byte and advances the device address. The number of tries is capped. A byte that still fails at the cap aborts the run with a fail flag and the failing address. In read mode the block walks the same address sequence and presents one captured byte per address. All delays come from a cycle-count timer derived from parameters.

States: IDLE, POWER (nominal supplies, settle wait), CLEAR, BOOST, INHIBIT, FETCH, WRITE, WINH, VERIFY, OVER, OINH, ACK, ADVANCE, RVERIFY, RADVANCE, RINH, ECLEAR, DROP. Transitions:
- IDLE→POWER on start.
- POWER→CLEAR→BOOST→INHIBIT, each when its delay expires.
- INHIBIT→FETCH in burn mode, or INHIBIT→RVERIFY in read mode.
- FETCH→WRITE on source valid.
- WRITE→WINH→VERIFY on their delays.
- VERIFY→OVER on a match. On a mismatch, VERIFY→WRITE below the cap or VERIFY→ECLEAR at the cap.
- OVER→OINH→ACK→ADVANCE.
- ADVANCE→FETCH after the burst, or ADVANCE→ECLEAR when the last address is done.
- RVERIFY→RADVANCE.
- RADVANCE→RVERIFY after the burst, or RADVANCE→RINH after the last address.
- RINH→ECLEAR→DROP→IDLE.

Top module: `prom_burn_sequencer`

## Requirements
- R1: After reset and whenever idle, mode_sel is 0000, adv_clk is low, all three supply enables are low, data_oe is low, src_ready is low and busy is low.
- R2: On start, vdd_on and vpp_on rise while boost_on stays low. After SETTLE_US the mode becomes clear (mode_sel = 4'b0101, bit 0 being the first select line). Boost rises STEP_US later with mode still clear. The mode becomes inhibit (4'b1101) STEP_US after that.
- R3: Every write pulse uses mode 4'b1110 with data_oe high and data_out equal to the source byte. Each ordinary pulse lasts exactly one millisecond (CYC_PER_US*US_PER_MS cycles).
- R4: Each write pulse is followed by inhibit and then one verify interval (mode 4'b1100, data_oe low). At the end of verify, the block compares dev_data_in with the byte. A mismatch below the cap starts another write pulse. A byte that needs X pulses therefore sees X verifies.
- R5: After a matching verify, one write pulse of X milliseconds is applied, followed by inhibit.
- R6: src_ready is high for exactly one cycle per address, only after that address's over-programming pulse, and only while src_valid is high.
- R7: The device address is advanced by exactly four adv_clk pulses per address. Pulses occur only in inhibit or verify mode, so consecutive bytes land at consecutive device addresses.
- R8: If the verify after pulse MAX_TRIES still mismatches, fail is set and fail_addr holds that address. No further write occurs, and later bytes are not acknowledged. A byte that passes exactly at pulse MAX_TRIES is not a failure.
- R9: Every run ends with clear mode, then boost off with nominal supplies still on for STEP_US, then all supplies off together with a one-cycle done pulse.
- R10: In read mode the sequence is clear, inhibit, verify. The block performs no writes and pulses rd_valid once per address, with rd_addr counting from 0 and rd_data equal to the device byte. Four adv_clk pulses separate consecutive reads.
- R11: start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| read_mode | input | 1 | 1 = read-back run, 0 = burn run |
| last_addr | input | ADDR_W | Final device address of the run |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte accepted |
| dev_data_in | input | 8 | Byte bus as driven by the device |
| mode_sel | output | 4 | Mode-select lines, bit 0 first |
| adv_clk | output | 1 | Device address-advance clock |
| data_out | output | 8 | Byte driven toward the device |
| data_oe | output | 1 | Enable for data_out |
| vdd_on | output | 1 | Device supply enable |
| vpp_on | output | 1 | Programming-pin supply enable |
| boost_on | output | 1 | Raise both supplies to programming levels |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last burn run aborted at the try cap |
| fail_addr | output | ADDR_W | Address that failed |
| rd_valid | output | 1 | Read-back byte valid (one cycle) |
| rd_data | output | 8 | Read-back byte |
| rd_addr | output | ADDR_W | Address of the read-back byte |

## Verification
The hardest cases to reach are the two ends of the adaptive loop: a byte that passes on exactly the last allowed pulse, and a byte that never passes. The bench contains a behavioural device model. It holds a per-address count of the write time needed before the cell takes its value, and it advances its own address only on clear and on groups of four clock rises. Setting one address's need equal to the cap and another's one above it drives the block into both branches. It also exposes any address slip as wrong device contents.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

    localparam int BYTE_W = 8;

    // mode_sel bit 0 is the first select line
    localparam logic [3:0] MODE_OFF     = 4'b0000;
    localparam logic [3:0] MODE_CLEAR   = 4'b0101;
    localparam logic [3:0] MODE_WRITE   = 4'b1110;
    localparam logic [3:0] MODE_VERIFY  = 4'b1100;
    localparam logic [3:0] MODE_INHIBIT = 4'b1101;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_POWER,
        ST_CLEAR,
        ST_BOOST,
        ST_INHIBIT,
        ST_FETCH,
        ST_WRITE,
        ST_WINH,
        ST_VERIFY,
        ST_OVER,
        ST_OINH,
        ST_ACK,
        ST_ADVANCE,
        ST_RVERIFY,
        ST_RADVANCE,
        ST_RINH,
        ST_ECLEAR,
        ST_DROP
    } seq_state_t;

endpackage

// File: rtl/prom_seq_timer.sv
module prom_seq_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // a load of N makes the current state last N cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/prom_seq_burst.sv
module prom_seq_burst #(
    parameter int PULSES   = 4,
    parameter int HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic pulse_out,
    output logic done
);

    localparam int HW    = $clog2(HALF_CYC + 1);
    localparam int HALVES = 2 * PULSES;
    localparam int EW    = $clog2(HALVES + 1);

    logic          active;
    logic [HW-1:0] hcnt;
    logic [EW-1:0] halves;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pulse_out <= 1'b0;
            done      <= 1'b0;
            hcnt      <= '0;
            halves    <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active    <= 1'b1;
                    pulse_out <= 1'b1;
                    hcnt      <= HW'(HALF_CYC - 1);
                    halves    <= '0;
                end
            end else if (hcnt != '0) begin
                hcnt <= hcnt - 1'b1;
            end else begin
                hcnt <= HW'(HALF_CYC - 1);
                if (halves == EW'(HALVES - 1)) begin
                    active    <= 1'b0;
                    pulse_out <= 1'b0;
                    done      <= 1'b1;
                end else begin
                    halves    <= halves + 1'b1;
                    pulse_out <= ~pulse_out;
                end
            end
        end
    end

endmodule

// File: rtl/prom_burn_sequencer.sv
module prom_burn_sequencer
    import prom_seq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int CYC_PER_US = 250,
    parameter int US_PER_MS  = 1000,
    parameter int SETTLE_US  = 10,
    parameter int STEP_US    = 1,
    parameter int MAX_TRIES  = 25,
    parameter int ADV_PULSES = 4,
    parameter int TW         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              read_mode,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    input  logic [7:0]        dev_data_in,
    output logic [3:0]        mode_sel,
    output logic              adv_clk,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              vdd_on,
    output logic              vpp_on,
    output logic              boost_on,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int MS_CYC     = CYC_PER_US * US_PER_MS;
    localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
    localparam int STEP_CYC   = CYC_PER_US * STEP_US;
    localparam int TRY_W      = $clog2(MAX_TRIES + 1);

    seq_state_t state, nxt;

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;
    logic              burst_go;
    logic              burst_done;
    logic              adv_pulse;

    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] byte_q;
    logic [TRY_W-1:0]  tries_q;
    logic              read_q;
    logic              fail_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              done_q;
    logic              rd_valid_q;
    logic [BYTE_W-1:0] rd_data_q;
    logic [ADDR_W-1:0] rd_addr_q;

    logic              at_last;
    logic              match;
    logic              at_cap;

    assign at_last = (addr_q == last_addr);
    assign match   = (dev_data_in == byte_q);
    assign at_cap  = (tries_q == TRY_W'(MAX_TRIES));

    prom_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    prom_seq_burst #(.PULSES(ADV_PULSES), .HALF_CYC(STEP_CYC)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (burst_go),
        .pulse_out (adv_pulse),
        .done      (burst_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions and delay loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = TW'(STEP_CYC);
        burst_go = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                nxt = ST_POWER; tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC);
            end
            ST_POWER:   if (tmr_exp) begin nxt = ST_CLEAR;   tmr_load = 1'b1; end
            ST_CLEAR:   if (tmr_exp) begin nxt = ST_BOOST;   tmr_load = 1'b1; end
            ST_BOOST:   if (tmr_exp) begin nxt = ST_INHIBIT; tmr_load = 1'b1; end
            ST_INHIBIT: if (tmr_exp) begin
                nxt = read_q ? ST_RVERIFY : ST_FETCH; tmr_load = read_q;
            end
            ST_FETCH: if (src_valid) begin
                nxt = ST_WRITE; tmr_load = 1'b1; tmr_val = TW'(MS_CYC);
            end
            ST_WRITE:   if (tmr_exp) begin nxt = ST_WINH;   tmr_load = 1'b1; end
            ST_WINH:    if (tmr_exp) begin nxt = ST_VERIFY; tmr_load = 1'b1; end
            ST_VERIFY: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (match) begin
                    nxt = ST_OVER; tmr_val = TW'(tries_q) * TW'(MS_CYC);
                end else if (at_cap) begin
                    nxt = ST_ECLEAR;
                end else begin
                    nxt = ST_WRITE; tmr_val = TW'(MS_CYC);
                end
            end
            ST_OVER: if (tmr_exp) begin nxt = ST_OINH; tmr_load = 1'b1; end
            ST_OINH: if (tmr_exp) nxt = ST_ACK;
            ST_ACK: begin nxt = ST_ADVANCE; burst_go = 1'b1; end
            ST_ADVANCE: if (burst_done) begin
                nxt = at_last ? ST_ECLEAR : ST_FETCH; tmr_load = at_last;
            end
            ST_RVERIFY: if (tmr_exp) begin nxt = ST_RADVANCE; burst_go = 1'b1; end
            ST_RADVANCE: if (burst_done) begin
                nxt = at_last ? ST_RINH : ST_RVERIFY; tmr_load = 1'b1;
            end
            ST_RINH:   if (tmr_exp) begin nxt = ST_ECLEAR; tmr_load = 1'b1; end
            ST_ECLEAR: if (tmr_exp) begin nxt = ST_DROP;   tmr_load = 1'b1; end
            ST_DROP:   if (tmr_exp) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // run datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            byte_q      <= '0;
            tries_q     <= '0;
            read_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            done_q      <= 1'b0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
            rd_addr_q   <= '0;
        end else begin
            done_q     <= (state == ST_DROP) && tmr_exp;
            rd_valid_q <= (state == ST_RVERIFY) && tmr_exp;
            if (state == ST_IDLE && start) begin
                addr_q      <= '0;
                read_q      <= read_mode;
                fail_q      <= 1'b0;
                fail_addr_q <= '0;
            end
            if (state == ST_FETCH && src_valid) begin
                byte_q  <= src_data;
                tries_q <= TRY_W'(1);
            end
            if (state == ST_VERIFY && tmr_exp && !match) begin
                if (at_cap) begin
                    fail_q      <= 1'b1;
                    fail_addr_q <= addr_q;
                end else begin
                    tries_q <= tries_q + 1'b1;
                end
            end
            if ((state == ST_ADVANCE || state == ST_RADVANCE) && burst_done && !at_last)
                addr_q <= addr_q + 1'b1;
            if (state == ST_RVERIFY && tmr_exp) begin
                rd_data_q <= dev_data_in;
                rd_addr_q <= addr_q;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        mode_sel  = MODE_OFF;
        boost_on  = 1'b0;
        data_oe   = 1'b0;
        src_ready = 1'b0;
        unique case (state)
            ST_IDLE, ST_POWER: mode_sel = MODE_OFF;
            ST_CLEAR:          mode_sel = MODE_CLEAR;
            ST_BOOST, ST_ECLEAR: begin mode_sel = MODE_CLEAR; boost_on = 1'b1; end
            ST_DROP:           mode_sel = MODE_CLEAR;
            ST_INHIBIT, ST_FETCH, ST_WINH, ST_OINH, ST_ADVANCE, ST_RINH: begin
                mode_sel = MODE_INHIBIT; boost_on = 1'b1;
            end
            ST_ACK: begin mode_sel = MODE_INHIBIT; boost_on = 1'b1; src_ready = 1'b1; end
            ST_WRITE, ST_OVER: begin mode_sel = MODE_WRITE; boost_on = 1'b1; data_oe = 1'b1; end
            ST_VERIFY, ST_RVERIFY, ST_RADVANCE: begin mode_sel = MODE_VERIFY; boost_on = 1'b1; end
            default: mode_sel = MODE_OFF;
        endcase
    end

    assign vdd_on    = (state != ST_IDLE);
    assign vpp_on    = (state != ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign adv_clk   = adv_pulse;
    assign data_out  = byte_q;
    assign done      = done_q;
    assign fail      = fail_q;
    assign fail_addr = fail_addr_q;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign rd_addr   = rd_addr_q;

endmodule

// File: rtl/prom_burn_sequencer_chk.sv
module prom_burn_sequencer_chk
    import prom_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       src_valid,
    input logic       src_ready,
    input logic [3:0] mode_sel,
    input logic       adv_clk,
    input logic       data_oe,
    input logic       vdd_on,
    input logic       vpp_on,
    input logic       boost_on,
    input logic       busy,
    input logic       done,
    input logic       fail
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mode_sel == MODE_OFF) && !adv_clk && !vdd_on && !boost_on);

    // R2
    boost_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boost_on |-> vdd_on && vpp_on);

    // R3
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (mode_sel == MODE_WRITE) && boost_on);

    // R6
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |=> !src_ready);

    // R6
    ready_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> src_valid);

    // R7
    adv_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_clk |-> (mode_sel == MODE_INHIBIT) || (mode_sel == MODE_VERIFY));

    // R8
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (mode_sel != MODE_WRITE));

    // R9
    done_powered_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vdd_on && !boost_on && !busy);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

endmodule

bind prom_burn_sequencer prom_burn_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .mode_sel  (mode_sel),
    .adv_clk   (adv_clk),
    .data_oe   (data_oe),
    .vdd_on    (vdd_on),
    .vpp_on    (vpp_on),
    .boost_on  (boost_on),
    .busy      (busy),
    .done      (done),
    .fail      (fail)
);

// File: tb/prom_burn_sequencer_tb.sv
module prom_burn_sequencer_tb;
    import prom_seq_pkg::*;

    localparam int AW   = 4;
    localparam int CPU  = 2;
    localparam int UPM  = 5;
    localparam int SETU = 10;
    localparam int STPU = 1;
    localparam int MAXT = 6;
    localparam int MS   = CPU * UPM;
    localparam int STEP = CPU * STPU;
    localparam int SETC = CPU * SETU;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start, read_mode, src_valid;
    logic [AW-1:0] last_addr;
    logic [7:0]    src_data;
    logic          src_ready;
    logic [7:0]    dev_data_in;
    logic [3:0]    mode_sel;
    logic          adv_clk, data_oe, vdd_on, vpp_on, boost_on, busy, done, fail;
    logic [7:0]    data_out;
    logic [AW-1:0] fail_addr;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;

    always #2 clk = ~clk;

    prom_burn_sequencer #(
        .ADDR_W(AW), .CYC_PER_US(CPU), .US_PER_MS(UPM), .SETTLE_US(SETU),
        .STEP_US(STPU), .MAX_TRIES(MAXT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .read_mode(read_mode),
        .last_addr(last_addr), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .dev_data_in(dev_data_in), .mode_sel(mode_sel),
        .adv_clk(adv_clk), .data_out(data_out), .data_oe(data_oe),
        .vdd_on(vdd_on), .vpp_on(vpp_on), .boost_on(boost_on), .busy(busy),
        .done(done), .fail(fail), .fail_addr(fail_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_addr(rd_addr)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // behavioural device: address counter, cells that need a programmed time
    logic [7:0]    mem  [16];
    int            need [16];
    int            wcyc [16];
    logic [7:0]    dat  [16];
    logic [AW-1:0] daddr;
    int            grp, rises;
    logic          adv_d;

    task automatic erase();
        for (int i = 0; i < 16; i++) begin
            mem[i] = 8'hFF; wcyc[i] = 0; need[i] = 1;
        end
    endtask

    always @(posedge clk) begin
        adv_d <= adv_clk;
        if (mode_sel == MODE_CLEAR) begin
            daddr <= '0;
            grp   <= 0;
        end else if (adv_clk && !adv_d) begin
            rises <= rises + 1;
            if (grp == 3) begin grp <= 0; daddr <= daddr + 1'b1; end
            else grp <= grp + 1;
        end
        if (mode_sel == MODE_WRITE && data_oe && boost_on) begin
            wcyc[daddr] <= wcyc[daddr] + 1;
            if (wcyc[daddr] + 1 == need[daddr] * MS) mem[daddr] <= data_out;
        end
    end

    assign dev_data_in = (mode_sel == MODE_VERIFY) ? mem[daddr] : 8'h00;

    // scoreboard
    typedef struct {
        int         len;
        logic [7:0] data;
    } wr_item_t;

    wr_item_t   exp_wr[$];
    logic [7:0] exp_rd[$];

    int writes_seen, ver_cnt, acks, rd_count, vdd_rises, wlen, cyc;
    int t_vdd, t_vdd_off, t_clr, t_boost, t_boost_off, t_inh;
    bit done_seen;
    logic [7:0] wdat;
    logic [3:0] p_mode = MODE_OFF;
    logic p_vdd = 1'b0, p_boost = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mode_sel == MODE_WRITE) begin
                if (wlen == 0) wdat = data_out;
                wlen++;
                if (!data_oe) chk(0, "R3 oe low during write", 0, 1);
            end else if (wlen > 0) begin
                if (exp_wr.size() == 0) begin
                    chk(0, "R3 unexpected write pulse", wlen, 0);
                end else begin
                    wr_item_t it;
                    it = exp_wr.pop_front();
                    chk(wlen == it.len, "R3/R5 pulse length", wlen, it.len);
                    chk(wdat == it.data, "R3 pulse data", wdat, it.data);
                end
                writes_seen++;
                wlen = 0;
            end
            if (mode_sel == MODE_VERIFY && p_mode != MODE_VERIFY) ver_cnt++;
            if (rd_valid) begin
                if (exp_rd.size() == 0) chk(0, "R10 unexpected read byte", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rd.pop_front();
                    chk(rd_data == e, "R10 read byte", rd_data, e);
                end
                chk(rd_addr == AW'(rd_count), "R10 read address", rd_addr, rd_count);
                rd_count++;
            end
            if (src_ready && src_valid) acks++;
            if (done) done_seen = 1'b1;
            if (vdd_on && !p_vdd) begin t_vdd = cyc; vdd_rises++; end
            if (!vdd_on && p_vdd) t_vdd_off = cyc;
            if (boost_on && !p_boost) t_boost = cyc;
            if (!boost_on && p_boost) t_boost_off = cyc;
            if (mode_sel == MODE_CLEAR && p_mode == MODE_OFF) t_clr = cyc;
            if (mode_sel == MODE_INHIBIT && p_mode == MODE_CLEAR) t_inh = cyc;
        end
        p_mode  = mode_sel;
        p_vdd   = vdd_on;
        p_boost = boost_on;
    end

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R9 run never completed actual=0 expected=1");
        finish_test();
    end

    task automatic begin_run(input bit rd, input int last);
        done_seen = 1'b0; writes_seen = 0; ver_cnt = 0; acks = 0;
        rises = 0; rd_count = 0; vdd_rises = 0;
        @(negedge clk);
        read_mode = rd; last_addr = AW'(last); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // driver: pushes expected write pulses, then offers the byte
    task automatic feed(input int n);
        int cum = 0;
        for (int i = 0; i < n; i++) begin
            int x;
            wr_item_t it;
            x = (need[i] > MAXT) ? MAXT : need[i];
            for (int k = 0; k < x; k++) begin
                it.len = MS; it.data = dat[i]; exp_wr.push_back(it);
            end
            cum += x;
            if (need[i] <= MAXT) begin
                it.len = x * MS; it.data = dat[i]; exp_wr.push_back(it);
                cum++;
            end
            src_data = dat[i]; src_valid = 1'b1;
            do @(negedge clk); while (!src_ready && !done_seen);
            if (done_seen) begin
                src_valid = 1'b0;
                break;
            end
            // R6: accepted only once the over-programming pulse is finished
            chk(writes_seen == cum, "R6 ack after over-programming", writes_seen, cum);
            @(posedge clk);
            #1;
            src_valid = 1'b0;
        end
        src_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_seen) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; read_mode = 1'b0; src_valid = 1'b0;
        src_data = '0; last_addr = '0; adv_d = 1'b0; daddr = '0;
        grp = 0; rises = 0; wlen = 0; cyc = 0;
        erase();
        repeat (4) @(negedge clk);
        // R1
        chk(mode_sel == MODE_OFF, "R1 reset mode", mode_sel, 0);
        chk(!adv_clk && !vdd_on && !vpp_on && !boost_on, "R1 reset outputs", 1, 0);
        chk(!busy && !data_oe && !src_ready, "R1 reset busy/oe/ready", busy, 0);
        rst_n = 1'b1;

        // burn run: needs 1,3,2 and exactly the cap
        dat[0] = 8'hA5; dat[1] = 8'h3C; dat[2] = 8'h96; dat[3] = 8'h5A;
        need[0] = 1; need[1] = 3; need[2] = 2; need[3] = MAXT;
        begin_run(1'b0, 3);
        fork
            feed(4);
            begin
                repeat (60) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                // R11
                chk(busy && mode_sel != MODE_OFF, "R11 start while busy", busy, 1);
            end
        join
        wait_done();
        chk(vdd_rises == 1, "R11 single power-up", vdd_rises, 1);
        chk(t_clr - t_vdd == SETC, "R2 settle before clear", t_clr - t_vdd, SETC);
        chk(t_boost - t_clr == STEP, "R2 boost after clear", t_boost - t_clr, STEP);
        chk(t_inh - t_boost == STEP, "R2 inhibit after boost", t_inh - t_boost, STEP);
        chk(ver_cnt == 1 + 3 + 2 + MAXT, "R4 verify count", ver_cnt, 1 + 3 + 2 + MAXT);
        chk(exp_wr.size() == 0, "R5 all pulses seen", exp_wr.size(), 0);
        chk(acks == 4, "R6 ack count", acks, 4);
        chk(rises == 16, "R7 adv pulse count", rises, 16);
        for (int i = 0; i < 4; i++)
            chk(mem[i] == dat[i], "R7 device contents", mem[i], dat[i]);
        chk(!fail, "R8 pass at cap is not a failure", fail, 0);
        chk(t_vdd_off - t_boost_off == STEP, "R9 drop before off",
            t_vdd_off - t_boost_off, STEP);
        chk(!vdd_on && !busy, "R9 powered down", vdd_on, 0);

        // read run
        for (int i = 0; i < 4; i++) exp_rd.push_back(dat[i]);
        begin_run(1'b1, 3);
        wait_done();
        chk(rd_count == 4, "R10 bytes read", rd_count, 4);
        chk(exp_rd.size() == 0, "R10 all bytes seen", exp_rd.size(), 0);
        chk(writes_seen == 0, "R10 no writes", writes_seen, 0);
        chk(rises == 16, "R10 adv pulses", rises, 16);

        // burn run that exceeds the cap at address 1
        erase();
        dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33; dat[3] = 8'h44;
        need[0] = 2; need[1] = MAXT + 1; need[2] = 1; need[3] = 1;
        begin_run(1'b0, 3);
        feed(4);
        wait_done();
        chk(fail, "R8 fail flag", fail, 1);
        chk(fail_addr == 1, "R8 fail address", fail_addr, 1);
        chk(acks == 1, "R8 acks before failure", acks, 1);
        chk(writes_seen == 3 + MAXT, "R8 write pulses", writes_seen, 3 + MAXT);
        chk(exp_wr.size() == 0, "R8 expected pulses seen", exp_wr.size(), 0);
        chk(mem[2] == 8'hFF, "R8 later address untouched", mem[2], 8'hFF);
        chk(!vdd_on && !boost_on, "R9 powered down after fail", vdd_on, 0);

        finish_test();
    end

endmodule